// File: doc/BRIEF.md
# CAN Error Flag and Code Capture

This block sits beside a CAN protocol engine and records the error conditions that the engine reports. Eight single-cycle event inputs each set a sticky flag. The flags cover bus lock, overload frame, receive overrun, bus-off recovery, bus-off entry, error passive, error warning and bus error. A per-flag enable mask turns the flags into a single pending condition. That condition is shown as bit 5 of a status register and drives the error interrupt once the matching interrupt-enable bit is set.

Alongside the flags, a separate error-code register records the type of each bus error that the engine reports. A mode bit chooses between two behaviours. In one, codes pile up across several errors. In the other, only the most recent error's code is kept. Software clears flags and code bits with a write-zero-to-clear rule: a write of 1 to a bit leaves it untouched. The transmit and receive error counts come from the engine and are read through the same register bus without any change.

Top module: `can_errcap`

## Requirements
- R1: After reset, the flag, enable, error-code (including the mode bit) and interrupt-enable registers read 0, and `err_irq_o` is low.
- R2: A high cycle on `evt_i[k]` sets flag bit k of the flag register (address 0). Bit 7 down to 0 are, in order: bus lock, overload, receive overrun, bus-off recovery, bus-off entry, error passive, error warning and bus error. A set flag stays set until it is cleared.
- R3: A write to address 0 clears each flag whose data bit is 0. Flags whose data bit is 1 keep their value.
- R4: If an event arrives in the same cycle as a write that clears its flag, the flag is left set.
- R5: The enable register (address 1) reads back what was written. Bit 5 of the status register (address 4) is 1 exactly when some flag and its enable bit are both 1, and all other status bits read 0. Writes to address 4 have no effect.
- R6: `err_irq_o` is status bit 5 ANDed with bit 5 of the interrupt-enable register (address 3). Only bit 5 of address 3 is stored; its other bits read 0. The interrupt stays high until every enabled flag is cleared.
- R7: The error-code register is at address 2. Bits 6 down to 0 are, in order: ACK delimiter, bit error dominant, bit error recessive, CRC, ACK, form and stuff. Bit 7 is the mode bit. When the mode bit is 1, each `code_vld_i` ORs `code_i` into bits 6:0.
- R8: When the mode bit is 0, each `code_vld_i` replaces bits 6:0 with `code_i`.
- R9: A write to address 2 sets the mode bit to data bit 7 and clears code bits whose data bit is 0. If a code is captured in the same cycle, the captured code bits end up set.
- R10: Address 5 reads `tec_i` and address 6 reads `rec_i`. Writes to either address have no effect, and address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 8 | Error event pulses, one per flag |
| code_vld_i | input | 1 | Bus error code is valid this cycle |
| code_i | input | 7 | Bus error type bits |
| tec_i | input | 8 | Transmit error count from the engine |
| rec_i | input | 8 | Receive error count from the engine |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data (combinational) |
| err_irq_o | output | 1 | Error interrupt |

## Verification
All of this block's state can be read directly over the register bus, so a wrong flag, enable or code bit appears in `rdata_o` on the first read after the clock edge that corrupts it. A lost set-versus-clear priority, or a clear that reaches the wrong bits, shows up as a single wrong bit in the flag or code readback. The bench therefore reads every register back after each stimulus cycle. A wrong interrupt gate shows on `err_irq_o` within the same cycle in which the flag, enable or interrupt-enable register changes.

// File: rtl/can_errcap_pkg.sv
package can_errcap_pkg;

  // Register map of the error capture block
  typedef enum logic [2:0] {
    REG_FLAGS  = 3'd0,
    REG_ENABLE = 3'd1,
    REG_CODE   = 3'd2,
    REG_IRQEN  = 3'd3,
    REG_STATUS = 3'd4,
    REG_TXCNT  = 3'd5,
    REG_RXCNT  = 3'd6
  } errcap_addr_e;

  // Bit holding the pending error condition in the status and irq-enable registers
  localparam int unsigned ERR_IRQ_BIT = 5;

endpackage

// File: rtl/can_errcap_rst_sync.sv
module can_errcap_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/can_errcap_flags.sv
module can_errcap_flags #(
  parameter int unsigned NUM_FLAGS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] evt_i,
  input  logic                 flag_we_i,
  input  logic                 en_we_i,
  input  logic [NUM_FLAGS-1:0] wdata_i,
  output logic [NUM_FLAGS-1:0] flags_o,
  output logic [NUM_FLAGS-1:0] enable_o,
  output logic                 pend_o
);

  logic [NUM_FLAGS-1:0] flag_q;
  logic [NUM_FLAGS-1:0] flag_d;
  logic [NUM_FLAGS-1:0] en_q;
  logic [NUM_FLAGS-1:0] en_d;

  for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_flag
    logic keep;

    always_comb begin
      keep = flag_q[k];
      if (flag_we_i && !wdata_i[k]) begin
        keep = 1'b0;
      end
      // a new event overrides a simultaneous clear
      flag_d[k] = keep | evt_i[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[k] <= 1'b0;
      end else begin
        flag_q[k] <= flag_d[k];
      end
    end

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[k] |=> flag_q[k]); // R2

    AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we_i && !wdata_i[k] && !evt_i[k]) |=> !flag_q[k]); // R3

    AST_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we_i && wdata_i[k] && !evt_i[k]) |=> $stable(flag_q[k])); // R3

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we_i && !wdata_i[k] && evt_i[k]) |=> flag_q[k]); // R4
  end

  always_comb begin
    en_d = en_q;
    if (en_we_i) begin
      en_d = wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else begin
      en_q <= en_d;
    end
  end

  assign flags_o  = flag_q;
  assign enable_o = en_q;
  assign pend_o   = |(flag_q & en_q);

  AST_NO_FLAG_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q == '0) |-> !pend_o); // R5

endmodule

// File: rtl/can_errcap_code.sv
module can_errcap_code #(
  parameter int unsigned CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              we_i,
  input  logic [CODE_W:0]   wdata_i,
  output logic [CODE_W-1:0] code_o,
  output logic              accum_o
);

  localparam int unsigned MODE_POS = CODE_W;

  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] code_d;
  logic [CODE_W-1:0] kept;
  logic              mode_q;
  logic              mode_d;

  always_comb begin
    kept   = code_q;
    mode_d = mode_q;
    if (we_i) begin
      kept   = code_q & wdata_i[CODE_W-1:0];
      mode_d = wdata_i[MODE_POS];
    end
    code_d = kept;
    if (vld_i) begin
      if (mode_q) begin
        code_d = kept | code_i;
      end else begin
        code_d = code_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      mode_q <= 1'b0;
    end else begin
      code_q <= code_d;
      mode_q <= mode_d;
    end
  end

  assign code_o  = code_q;
  assign accum_o = mode_q;

  AST_ACCUM_ADDS: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && mode_q) |=> ((code_q & $past(code_i)) == $past(code_i))); // R7

  AST_ACCUM_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && mode_q && !we_i) |=> ((code_q & $past(code_q)) == $past(code_q))); // R7

  AST_LATEST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && !mode_q) |=> (code_q == $past(code_i))); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!vld_i && !we_i) |=> ($stable(code_q) && $stable(mode_q))); // R9

endmodule

// File: rtl/can_errcap_regs.sv
module can_errcap_regs
  import can_errcap_pkg::*;
#(
  parameter int unsigned NUM_FLAGS = 8,
  parameter int unsigned CODE_W    = 7,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NUM_FLAGS-1:0] flags_i,
  input  logic [NUM_FLAGS-1:0] enable_i,
  input  logic              pend_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              accum_i,
  input  logic [CNT_W-1:0]  tec_i,
  input  logic [CNT_W-1:0]  rec_i,
  output logic              flag_we_o,
  output logic              en_we_o,
  output logic              code_we_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);

  logic irqen_q;
  logic irqen_d;
  logic irqen_we;

  always_comb begin
    flag_we_o = wr_en_i && (addr_i == ADDR_W'(REG_FLAGS));
    en_we_o   = wr_en_i && (addr_i == ADDR_W'(REG_ENABLE));
    code_we_o = wr_en_i && (addr_i == ADDR_W'(REG_CODE));
    irqen_we  = wr_en_i && (addr_i == ADDR_W'(REG_IRQEN));
  end

  always_comb begin
    irqen_d = irqen_q;
    if (irqen_we) begin
      irqen_d = wdata_i[ERR_IRQ_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irqen_q <= 1'b0;
    end else begin
      irqen_q <= irqen_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(REG_FLAGS):  rdata_o = DATA_W'(flags_i);
      ADDR_W'(REG_ENABLE): rdata_o = DATA_W'(enable_i);
      ADDR_W'(REG_CODE):   rdata_o = DATA_W'({accum_i, code_i});
      ADDR_W'(REG_IRQEN):  rdata_o[ERR_IRQ_BIT] = irqen_q;
      ADDR_W'(REG_STATUS): rdata_o[ERR_IRQ_BIT] = pend_i;
      ADDR_W'(REG_TXCNT):  rdata_o = DATA_W'(tec_i);
      ADDR_W'(REG_RXCNT):  rdata_o = DATA_W'(rec_i);
      default:             rdata_o = '0;
    endcase
  end

  assign irq_o = pend_i & irqen_q;

  AST_IRQEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    irqen_we |=> (irqen_q == $past(wdata_i[ERR_IRQ_BIT]))); // R6

  AST_NO_PEND_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_i |-> !irq_o); // R6

endmodule

// File: rtl/can_errcap.sv
module can_errcap #(
  parameter int unsigned NUM_FLAGS = 8,
  parameter int unsigned CODE_W    = 7,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] evt_i,
  input  logic                 code_vld_i,
  input  logic [CODE_W-1:0]    code_i,
  input  logic [CNT_W-1:0]     tec_i,
  input  logic [CNT_W-1:0]     rec_i,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 err_irq_o
);

  logic                 rst_s_n;
  logic [NUM_FLAGS-1:0] flags;
  logic [NUM_FLAGS-1:0] enables;
  logic                 pend;
  logic [CODE_W-1:0]    code;
  logic                 accum;
  logic                 flag_we;
  logic                 en_we;
  logic                 code_we;

  can_errcap_rst_sync #(.STAGES(RST_STAGES)) i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  can_errcap_flags #(.NUM_FLAGS(NUM_FLAGS)) i_flags (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .evt_i     (evt_i),
    .flag_we_i (flag_we),
    .en_we_i   (en_we),
    .wdata_i   (wdata_i[NUM_FLAGS-1:0]),
    .flags_o   (flags),
    .enable_o  (enables),
    .pend_o    (pend)
  );

  can_errcap_code #(.CODE_W(CODE_W)) i_code (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .vld_i   (code_vld_i),
    .code_i  (code_i),
    .we_i    (code_we),
    .wdata_i (wdata_i[CODE_W:0]),
    .code_o  (code),
    .accum_o (accum)
  );

  can_errcap_regs #(
    .NUM_FLAGS (NUM_FLAGS),
    .CODE_W    (CODE_W),
    .CNT_W     (CNT_W),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
  ) i_regs (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .flags_i   (flags),
    .enable_i  (enables),
    .pend_i    (pend),
    .code_i    (code),
    .accum_i   (accum),
    .tec_i     (tec_i),
    .rec_i     (rec_i),
    .flag_we_o (flag_we),
    .en_we_o   (en_we),
    .code_we_o (code_we),
    .rdata_o   (rdata_o),
    .irq_o     (err_irq_o)
  );

  AST_IRQ_IDLE_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_s_n)
    (flags == '0) |-> !err_irq_o); // R6

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_s_n) |-> (!err_irq_o && flags == '0 && code == '0)); // R1

endmodule

// File: tb/test_can_errcap.sv
`timescale 1ns/1ps
module test_can_errcap;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] evt_i;
  logic       code_vld_i;
  logic [6:0] code_i;
  logic [7:0] tec_i;
  logic [7:0] rec_i;
  logic       wr_en_i;
  logic [2:0] addr_i;
  logic [7:0] wdata_i;
  logic [7:0] rdata_o;
  logic       err_irq_o;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  can_errcap i_can_errcap (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .code_vld_i(code_vld_i),
    .code_i(code_i), .tec_i(tec_i), .rec_i(rec_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .err_irq_o(err_irq_o)
  );

  // {event pulses, write flag reg, write data, expected flags}
  localparam logic [24:0] VEC [8] = '{
    {8'h81, 1'b0, 8'h00, 8'h81},  // R2 set bus lock and bus error
    {8'h24, 1'b0, 8'h00, 8'hA5},  // R2 set overrun and passive
    {8'h00, 1'b1, 8'hFE, 8'hA4},  // R3 clear bit 0 only
    {8'h80, 1'b1, 8'h7F, 8'hA4},  // R4 event beats clear on bit 7
    {8'h00, 1'b1, 8'hDB, 8'h80},  // R3 clear bits 5 and 2
    {8'h5A, 1'b1, 8'h00, 8'h5A},  // R4 clear all while new events arrive
    {8'h00, 1'b1, 8'hFF, 8'h5A},  // R3 all-ones write keeps flags
    {8'h00, 1'b1, 8'h00, 8'h00}   // R3 clear all
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [7:0] ev, input logic cv, input logic [6:0] cd,
                     input logic wr, input logic [2:0] ad, input logic [7:0] wd);
    @(negedge clk);
    evt_i = ev; code_vld_i = cv; code_i = cd;
    wr_en_i = wr; addr_i = ad; wdata_i = wd;
    @(posedge clk);
    #1;
    evt_i = '0; code_vld_i = 1'b0; code_i = '0; wr_en_i = 1'b0;
  endtask

  task automatic wr(input logic [2:0] ad, input logic [7:0] wd);
    cyc(8'h00, 1'b0, 7'h00, 1'b1, ad, wd);
  endtask

  task automatic rd(input logic [2:0] ad, output logic [7:0] d);
    @(negedge clk);
    addr_i = ad;
    #1;
    d = rdata_o;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; evt_i = '0; code_vld_i = 1'b0; code_i = '0;
    tec_i = 8'h12; rec_i = 8'h34; wr_en_i = 1'b0; addr_i = '0; wdata_i = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      check("R1", d, 8'h00);
    end
    check("R1 irq", {7'b0, err_irq_o}, 8'h00);
    rd(3'd5, d); check("R10 tec", d, 8'h12);
    rd(3'd6, d); check("R10 rec", d, 8'h34);
    rd(3'd7, d); check("R10 unused", d, 8'h00);

    // R2 R3 R4 vector table
    for (int i = 0; i < 8; i++) begin
      cyc(VEC[i][24:17], 1'b0, 7'h00, VEC[i][16], 3'd0, VEC[i][15:8]);
      rd(3'd0, d);
      check($sformatf("R2/R3/R4 vec%0d", i), d, VEC[i][7:0]);
    end

    // R5 R6 enable, status and interrupt gating
    cyc(8'h02, 1'b0, 7'h00, 1'b0, 3'd0, 8'h00);
    rd(3'd4, d); check("R5 status masked", d, 8'h00);
    wr(3'd1, 8'h02);
    rd(3'd1, d); check("R5 enable readback", d, 8'h02);
    rd(3'd4, d); check("R5 status pending", d, 8'h20);
    check("R6 irq gated off", {7'b0, err_irq_o}, 8'h00);
    wr(3'd3, 8'hFF);
    rd(3'd3, d); check("R6 irqen readback", d, 8'h20);
    check("R6 irq on", {7'b0, err_irq_o}, 8'h01);
    wr(3'd4, 8'h00);
    rd(3'd4, d); check("R5 status write ignored", d, 8'h20);
    cyc(8'h08, 1'b0, 7'h00, 1'b1, 3'd1, 8'h0A);
    wr(3'd0, 8'hFD);
    rd(3'd0, d); check("R3 flags after clear", d, 8'h08);
    check("R6 irq held by other flag", {7'b0, err_irq_o}, 8'h01);
    wr(3'd0, 8'hF7);
    check("R6 irq released", {7'b0, err_irq_o}, 8'h00);
    rd(3'd4, d); check("R5 status idle", d, 8'h00);

    // R7 R8 R9 error codes
    wr(3'd2, 8'h80);
    rd(3'd2, d); check("R9 mode write", d, 8'h80);
    cyc(8'h00, 1'b1, 7'h41, 1'b0, 3'd0, 8'h00);
    rd(3'd2, d); check("R7 first code", d, 8'hC1);
    cyc(8'h00, 1'b1, 7'h08, 1'b0, 3'd0, 8'h00);
    rd(3'd2, d); check("R7 accumulate", d, 8'hC9);
    wr(3'd2, 8'hFE);
    rd(3'd2, d); check("R9 clear one code bit", d, 8'hC8);
    wr(3'd2, 8'h48);
    rd(3'd2, d); check("R9 mode off keeps bits", d, 8'h48);
    cyc(8'h00, 1'b1, 7'h02, 1'b0, 3'd0, 8'h00);
    rd(3'd2, d); check("R8 overwrite", d, 8'h02);
    cyc(8'h00, 1'b1, 7'h10, 1'b1, 3'd2, 8'h00);
    rd(3'd2, d); check("R9 capture beats clear", d, 8'h10);

    // R10 counts are read only
    tec_i = 8'hA7; rec_i = 8'h3C;
    wr(3'd5, 8'hFF);
    wr(3'd6, 8'h00);
    rd(3'd5, d); check("R10 tec after write", d, 8'hA7);
    rd(3'd6, d); check("R10 rec after write", d, 8'h3C);
    rd(3'd1, d); check("R10 enable untouched", d, 8'h0A);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule